// File: doc/BRIEF.md
# Acquisition Trigger and Arm Controller

The block merges three trigger sources into a single acquisition start pulse for a data framer: a software trigger taken from a control bit, a cascaded trigger arriving from a neighbouring instance, and a hardware trigger line. The hardware path must be armed first. A rising edge of the arm bit sets an armed flag. Accepting a hardware trigger clears that flag unless automatic re-arm is on. In continuous mode a hardware trigger is accepted without arming. In every mode, an acquisition starts only when a trigger arrives.

Each accepted trigger increments a 32-bit counter and latches the 64-bit time input. It also sets sticky status bits that record which sources fired. The start pulse is copied, one register later, to a cascaded trigger output that can feed the next instance. A trigger that arrives while the framer reports busy is dropped. It is not counted and not queued. The sticky bits stay set until software makes a rising edge on the clear bit.

Top module: `acq_trig_ctrl`

## Requirements
- R1: Each rising edge of `sw_trig_i` that is not dropped produces exactly one `start_o` pulse, one cycle wide, in the cycle after the clock edge that samples the rise.
- R2: A rising edge of `casc_trig_i` starts an acquisition only while `casc_en_i` is 1. While `casc_en_i` is 0 the edge has no effect on the start pulse, the counter or the status.
- R3: A rising edge of `hw_trig_i` is accepted only while the armed flag is set or `cont_mode_i` is 1. A rising edge of `arm_i` sets the flag, and this takes priority. Accepting a hardware trigger clears the flag unless `auto_rearm_i` is 1.
- R4: While `busy_i` is 1, trigger edges are dropped. There is no start pulse, no count, no status change and no change to the armed flag.
- R5: `trig_cnt_o` increases by one in the same cycle as each `start_o` pulse. It is otherwise constant and wraps at 2^32.
- R6: At the clock edge that raises `start_o`, `ts_sec_o` takes `time_i[63:32]` and `ts_nsec_o` takes `time_i[31:0]`. Between triggers both hold their values.
- R7: `status_o` bit 0 records a software trigger, bit 1 a cascaded trigger, bit 2 a hardware trigger, bit 4 any start, and bit 5 `freeze_i` seen high. The trigger bits are set together with the start they belong to. Each bit holds until a rising edge of `clr_stat_i`. A set in the same cycle as the clear wins over the clear.
- R8: `status_o` bit 3 shows the armed flag. The clear-status edge does not affect it.
- R9: `casc_trig_o` equals `start_o` delayed by one clock cycle.
- R10: After reset, all outputs are 0 and the armed flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_trig_i | input | 1 | Software trigger control bit |
| casc_en_i | input | 1 | Accept cascaded trigger |
| auto_rearm_i | input | 1 | Keep armed after hardware trigger |
| arm_i | input | 1 | Arm control bit, rising edge arms |
| clr_stat_i | input | 1 | Status clear bit, rising edge clears |
| cont_mode_i | input | 1 | 1: continuous, 0: triggered |
| hw_trig_i | input | 1 | Hardware trigger line |
| casc_trig_i | input | 1 | Cascaded trigger from neighbour |
| freeze_i | input | 1 | Freeze event indication |
| busy_i | input | 1 | Framer acquisition in progress |
| time_i | input | 64 | Time, seconds in upper word |
| start_o | output | 1 | Acquisition start pulse |
| casc_trig_o | output | 1 | Cascaded trigger to neighbour |
| status_o | output | 6 | Sticky status and armed flag |
| trig_cnt_o | output | 32 | Accepted trigger count |
| ts_sec_o | output | 32 | Latched seconds |
| ts_nsec_o | output | 32 | Latched nanoseconds |

## Verification
On every cycle, the assertions check the one-cycle delay to the cascade output, that the counter steps only with a start, that no start follows a busy cycle, that a cascaded edge alone cannot start while masked, that the armed flag is cleared and held correctly, and that sticky bits set and hold. The bench's scenarios are the only way to show the combined sequences. These are: arm, fire and try to fire again; two hardware triggers under auto re-arm; continuous mode with no arm; triggers dropped while busy; a set and a clear in the same cycle; and the timestamp matching the time sampled at the trigger edge.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  localparam int ST_SW    = 0;
  localparam int ST_CASC  = 1;
  localparam int ST_HW    = 2;
  localparam int ST_ARMED = 3;
  localparam int ST_COMB  = 4;
  localparam int ST_FRZ   = 5;
  localparam int ST_W     = 6;
  localparam int N_STICKY = 5;  // sw, casc, hw, comb, freeze
  localparam int N_EDGE   = 5;  // sw, casc, hw, arm, clr
  localparam int E_SW = 0, E_CASC = 1, E_HW = 2, E_ARM = 3, E_CLR = 4;
endpackage

// File: rtl/acq_edge_det.sv
module acq_edge_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/acq_trig_qual.sv
module acq_trig_qual (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_rise_i,
  input  logic       casc_rise_i,
  input  logic       hw_rise_i,
  input  logic       arm_rise_i,
  input  logic       casc_en_i,
  input  logic       auto_rearm_i,
  input  logic       cont_mode_i,
  input  logic       busy_i,
  output logic       fire_o,
  output logic [2:0] src_o,
  output logic       armed_o
);
  logic armed_q, hw_ok, casc_ok, hw_take;

  assign hw_ok   = hw_rise_i & (armed_q | cont_mode_i);
  assign casc_ok = casc_rise_i & casc_en_i;
  assign fire_o  = (sw_rise_i | casc_ok | hw_ok) & ~busy_i;
  assign src_o   = {hw_ok, casc_ok, sw_rise_i} & {3{fire_o}};
  assign hw_take = fire_o & hw_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     armed_q <= 1'b0;
    else if (arm_rise_i)             armed_q <= 1'b1;
    else if (hw_take && !auto_rearm_i) armed_q <= 1'b0;
  end
  assign armed_o = armed_q;

  assert_arm_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_take && !auto_rearm_i && !arm_rise_i) |=> !armed_o);
  assert_arm_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && auto_rearm_i) |=> armed_o);
  assert_busy_keeps_arm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !arm_rise_i) |=> $stable(armed_o));
endmodule

// File: rtl/acq_trig_status.sv
module acq_trig_status #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_rise_i,
  output logic [N-1:0] sticky_o
);
  logic [N-1:0] sticky_q;

  for (genvar g = 0; g < N; g++) begin : g_st
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sticky_q[g] <= 1'b0;
      else if (set_i[g])   sticky_q[g] <= 1'b1;  // set beats clear
      else if (clr_rise_i) sticky_q[g] <= 1'b0;
    end

    assert_sticky_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> sticky_o[g]);
    assert_sticky_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sticky_o[g] && !clr_rise_i) |=> sticky_o[g]);
  end
  assign sticky_o = sticky_q;
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 64,
  localparam int HALF_W = TIME_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_trig_i,
  input  logic              casc_en_i,
  input  logic              auto_rearm_i,
  input  logic              arm_i,
  input  logic              clr_stat_i,
  input  logic              cont_mode_i,
  input  logic              hw_trig_i,
  input  logic              casc_trig_i,
  input  logic              freeze_i,
  input  logic              busy_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              start_o,
  output logic              casc_trig_o,
  output logic [ST_W-1:0]   status_o,
  output logic [CNT_W-1:0]  trig_cnt_o,
  output logic [HALF_W-1:0] ts_sec_o,
  output logic [HALF_W-1:0] ts_nsec_o
);
  logic [N_EDGE-1:0]   lvl, rise;
  logic [N_STICKY-1:0] st_set, sticky;
  logic [2:0]          src;
  logic                fire, armed;
  logic                start_q, casc_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [TIME_W-1:0]   ts_q;

  always_comb begin
    lvl         = '0;
    lvl[E_SW]   = sw_trig_i;
    lvl[E_CASC] = casc_trig_i;
    lvl[E_HW]   = hw_trig_i;
    lvl[E_ARM]  = arm_i;
    lvl[E_CLR]  = clr_stat_i;
  end

  acq_edge_det #(.W(N_EDGE)) u_edge (
    .clk_i, .rst_ni, .lvl_i(lvl), .rise_o(rise)
  );

  acq_trig_qual u_qual (
    .clk_i, .rst_ni,
    .sw_rise_i   (rise[E_SW]),
    .casc_rise_i (rise[E_CASC]),
    .hw_rise_i   (rise[E_HW]),
    .arm_rise_i  (rise[E_ARM]),
    .casc_en_i, .auto_rearm_i, .cont_mode_i, .busy_i,
    .fire_o  (fire),
    .src_o   (src),
    .armed_o (armed)
  );

  assign st_set = {freeze_i, fire, src};

  acq_trig_status #(.N(N_STICKY)) u_stat (
    .clk_i, .rst_ni, .set_i(st_set), .clr_rise_i(rise[E_CLR]), .sticky_o(sticky)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      casc_q  <= 1'b0;
      cnt_q   <= '0;
      ts_q    <= '0;
    end else begin
      start_q <= fire;
      casc_q  <= start_q;
      if (fire) begin
        cnt_q <= cnt_q + 1'b1;
        ts_q  <= time_i;
      end
    end
  end

  assign start_o     = start_q;
  assign casc_trig_o = casc_q;
  assign trig_cnt_o  = cnt_q;
  assign ts_sec_o    = ts_q[TIME_W-1:HALF_W];
  assign ts_nsec_o   = ts_q[HALF_W-1:0];

  always_comb begin
    status_o           = '0;
    status_o[ST_SW]    = sticky[0];
    status_o[ST_CASC]  = sticky[1];
    status_o[ST_HW]    = sticky[2];
    status_o[ST_ARMED] = armed;
    status_o[ST_COMB]  = sticky[3];
    status_o[ST_FRZ]   = sticky[4];
  end

  assert_casc_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> casc_trig_o);
  assert_casc_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |=> !casc_trig_o);
  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (trig_cnt_o == CNT_W'($past(trig_cnt_o) + 1'b1)));
  assert_cnt_still_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> $stable(trig_cnt_o));
  assert_busy_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !start_o);
  assert_casc_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!casc_en_i && !sw_trig_i && !hw_trig_i) |=> !start_o);
endmodule

// File: tb/acq_trig_ctrl_tb_top.sv
module acq_trig_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw = 0, casc_en = 0, auto_r = 0, arm = 0, clr = 0, cont = 0;
  logic hw = 0, casc_in = 0, frz = 0, busy = 0;
  logic [63:0] tim = '0;
  logic        start, casc_out;
  logic [5:0]  status;
  logic [31:0] cnt, ts_s, ts_n;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acq_trig_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sw_trig_i(sw), .casc_en_i(casc_en),
    .auto_rearm_i(auto_r), .arm_i(arm), .clr_stat_i(clr), .cont_mode_i(cont),
    .hw_trig_i(hw), .casc_trig_i(casc_in), .freeze_i(frz), .busy_i(busy),
    .time_i(tim), .start_o(start), .casc_trig_o(casc_out), .status_o(status),
    .trig_cnt_o(cnt), .ts_sec_o(ts_s), .ts_nsec_o(ts_n)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tim <= {32'(cyc) * 32'd3 + 32'd11, 32'(cyc) * 32'd7 + 32'd5};
  end

  // behavioural reference model
  bit m_start, m_casc, m_armed;
  bit m_st[6];
  int unsigned m_cnt;
  longint unsigned m_ts;
  bit p_sw, p_casc, p_hw, p_arm, p_clr;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_start = 0; m_casc = 0; m_armed = 0; m_cnt = 0; m_ts = 0;
      foreach (m_st[i]) m_st[i] = 0;
      p_sw = 0; p_casc = 0; p_hw = 0; p_arm = 0; p_clr = 0;
    end else begin
      bit e_sw, e_casc, e_hw, e_arm, e_clr, ok_c, ok_h, v;
      e_sw = sw && !p_sw; e_casc = casc_in && !p_casc; e_hw = hw && !p_hw;
      e_arm = arm && !p_arm; e_clr = clr && !p_clr;
      ok_c = e_casc && casc_en;
      ok_h = e_hw && (m_armed || cont);
      v = (e_sw || ok_c || ok_h) && !busy;
      m_casc = m_start;
      m_start = v;
      if (v) begin m_cnt++; m_ts = tim; end
      if (e_arm) m_armed = 1;
      else if (v && ok_h && !auto_r) m_armed = 0;
      if (v && e_sw) m_st[0] = 1; else if (e_clr) m_st[0] = 0;
      if (v && ok_c) m_st[1] = 1; else if (e_clr) m_st[1] = 0;
      if (v && ok_h) m_st[2] = 1; else if (e_clr) m_st[2] = 0;
      if (v)         m_st[4] = 1; else if (e_clr) m_st[4] = 0;
      if (frz)       m_st[5] = 1; else if (e_clr) m_st[5] = 0;
      m_st[3] = m_armed;
      p_sw = sw; p_casc = casc_in; p_hw = hw; p_arm = arm; p_clr = clr;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [5:0] ms;
      ms = {m_st[5], m_st[4], m_st[3], m_st[2], m_st[1], m_st[0]};
      chk(start == m_start, "R1 start_o", start, m_start);
      chk(casc_out == m_casc, "R9 casc_trig_o", casc_out, m_casc);
      chk(cnt == m_cnt, "R5 trig_cnt_o", cnt, m_cnt);
      chk({ts_s, ts_n} == m_ts, "R6 timestamp", {ts_s, ts_n}, m_ts);
      chk(status[2:0] == ms[2:0] && status[5:4] == ms[5:4], "R7 sticky", status, ms);
      chk(status[3] == ms[3], "R8 armed", status[3], ms[3]);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    tick(3);
    // R10 reset state
    chk(start == 0 && casc_out == 0, "R10 pulses", {start, casc_out}, 0);
    chk(status == 0 && cnt == 0, "R10 status/count", {status, cnt}, 0);
    chk({ts_s, ts_n} == 0, "R10 timestamp", {ts_s, ts_n}, 0);
    rst_ni = 1;
    tick(2);
    // R1 software trigger
    sw = 1; tick(1); sw = 0; tick(3);
    chk(cnt == 1, "R1 sw count", cnt, 1);
    chk(status[0] && status[4], "R7 sw sticky", status, 6'h11);
    // R2 masked cascade
    casc_in = 1; tick(1); casc_in = 0; tick(3);
    chk(cnt == 1, "R2 masked casc count", cnt, 1);
    chk(!status[1], "R2 masked casc status", status[1], 0);
    casc_en = 1; casc_in = 1; tick(1); casc_in = 0; tick(3);
    chk(cnt == 2 && status[1], "R2 enabled casc", cnt, 2);
    // R3 hardware needs arm
    hw = 1; tick(1); hw = 0; tick(3);
    chk(cnt == 2 && !status[2], "R3 unarmed hw", cnt, 2);
    arm = 1; tick(1); arm = 0; tick(2);
    chk(status[3], "R8 armed set", status[3], 1);
    hw = 1; tick(1); hw = 0; tick(3);
    chk(cnt == 3 && status[2] && !status[3], "R3 armed hw", {cnt, status}, 3);
    hw = 1; tick(1); hw = 0; tick(3);
    chk(cnt == 3, "R3 disarmed hw", cnt, 3);
    // R3 auto re-arm
    auto_r = 1; arm = 1; tick(1); arm = 0; tick(2);
    hw = 1; tick(1); hw = 0; tick(3);
    hw = 1; tick(1); hw = 0; tick(3);
    chk(cnt == 5 && status[3], "R3 auto rearm", cnt, 5);
    // R4 busy drop
    busy = 1; sw = 1; tick(1); sw = 0; tick(1);
    hw = 1; tick(1); hw = 0; tick(2);
    chk(cnt == 5 && !start, "R4 busy drop", cnt, 5);
    busy = 0; tick(2);
    // R7 freeze, then clear
    frz = 1; tick(1); frz = 0; tick(2);
    chk(status[5], "R7 freeze sticky", status[5], 1);
    clr = 1; tick(1); clr = 0; tick(2);
    chk(status == 6'h08, "R7 clear keeps R8 armed", status, 6'h08);
    // R7 set wins over clear
    sw = 1; clr = 1; tick(1); sw = 0; clr = 0; tick(3);
    chk(status[0] && status[4], "R7 set beats clear", status, 6'h19);
    // R3 continuous mode without arm
    auto_r = 0; hw = 1; tick(1); hw = 0; tick(3);
    chk(!status[3] && cnt == 7, "R3 consume arm", {cnt, status}, 7);
    cont = 1; hw = 1; tick(1); hw = 0; tick(3);
    chk(cnt == 8, "R3 continuous hw", cnt, 8);
    cont = 0;
    // R6 timestamp reflects trigger edge
    tick(5);
    sw = 1; tick(1); sw = 0; tick(3);
    chk({ts_s, ts_n} == m_ts && m_ts != 0, "R6 latched time", {ts_s, ts_n}, m_ts);
    tick(4);
    finish_run();
  end
endmodule